// File: doc/BRIEF.md
# Priority Throttle Arbiter with Clock Pulse Skippers

This block settles competition between several throttle requests, for example a mild thermal alarm, a severe thermal alarm and over-current alarms. Each request line is a plain on/off input with no intermediate states. Each request has three configuration values: a priority, a CPU skip depth in percent and a 2-bit GPU skip level. Among the active requests, the one with the largest priority wins. Its settings drive two pulse skippers. Each skipper produces a per-cycle clock-enable strobe that drops a set share of the pulses in every 100-cycle window.

The block runs a free-running 100-cycle window counter. It samples the arbitration result only on the last cycle of a window. A new winner therefore takes effect on the first cycle of the next window, and never partway through one. Inside a window, each skipper uses a modulo-100 accumulator. The removed pulses are spread evenly and do not arrive in bursts. When no request is active, both strobes stay high. All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `throttle_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `win_valid_o` is 0 and both clock-enable outputs are 1.
- R2: Request i is bit i of `req_i`. Its priority is `prio_cfg_i[7i+6:7i]`, and a larger value means a higher priority. The applied winner is the active request with the largest priority, reported on `win_idx_o` with `win_valid_o` at 1.
- R3: When two active requests share the largest priority, the lower index wins.
- R4: The requests are sampled only on phase 99 of each window, where phase 0 is the first cycle after reset. The result is applied from the next phase 0 and held constant for all 100 cycles. A request that rises and falls between two samples has no effect.
- R5: The CPU skip depth N is `cpu_pct_cfg_i[7i+6:7i]` of the winner. Within each window, the CPU enable is low at phase p exactly when floor((p+1)N/100) > floor(pN/100). This drops N of every 100 pulses.
- R6: The GPU level is `gpu_lvl_cfg_i[2i+1:2i]`. Code 0 removes 0 pulses, code 1 removes 50, code 2 removes 75 and code 3 removes 85 per window, placed by the same rule as R5.
- R7: While no winner is applied, both enables are 1 on every cycle and `win_valid_o` is 0.
- R8: A CPU depth above 100 is treated as 100, so the CPU enable stays low for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Throttle request lines, one bit per request |
| prio_cfg_i | input | NUM_REQ*PRIO_W | Packed per-request priorities |
| cpu_pct_cfg_i | input | NUM_REQ*PCT_W | Packed per-request CPU skip depths in percent |
| gpu_lvl_cfg_i | input | NUM_REQ*2 | Packed per-request GPU skip level codes |
| cpu_clk_en_o | output | 1 | CPU clock-enable strobe |
| gpu_clk_en_o | output | 1 | GPU clock-enable strobe |
| win_valid_o | output | 1 | A winning request is applied in this window |
| win_idx_o | output | IDX_W | Index of the applied winner |

## Verification
A corrupted window counter moves the point where the winner changes away from the 100-cycle boundary. It also breaks the pulse pattern within one window, so the fault shows up on the first window after reset. A wrong accumulator value shifts which phases lose their enable, and the bench's per-phase comparison catches this on the first misplaced pulse. A wrong arbitration or latched winner changes `win_idx_o` and the pulse totals of the very next window. A winner that is latched outside the boundary shows up as an index change in the middle of a window.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int WIN_LEN = 100;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } gpu_lvl_e;

  function automatic logic [6:0] lvl_to_pct(gpu_lvl_e lvl);
    case (lvl)
      LVL_LOW:  return 7'd50;
      LVL_MED:  return 7'd75;
      LVL_HIGH: return 7'd85;
      default:  return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/thr_prio_pick.sv
module thr_prio_pick #(
  parameter int NUM_REQ = 4,
  parameter int PRIO_W  = 7,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRIO_W-1:0] best;

  // Scan from the top index down; ">=" lets a lower index take over on a tie.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] >= best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/thr_pulse_skip.sv
module thr_pulse_skip
  import thr_pkg::*;
#(
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCT_W-1:0] depth_i,
  input  logic             win_start_i,
  input  logic             win_end_i,
  output logic             en_o
);
  localparam int SUM_W = PCT_W + 1;

  logic [PCT_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic             skip;

  assign sum  = SUM_W'(acc_q) + SUM_W'(depth_i);
  assign skip = sum >= SUM_W'(WIN_LEN);
  assign en_o = ~skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (win_end_i) acc_q <= '0;
    else if (skip)      acc_q <= PCT_W'(sum - SUM_W'(WIN_LEN));
    else                acc_q <= PCT_W'(sum);
  end

  p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < PCT_W'(WIN_LEN));
  p_acc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_i |-> acc_q == '0);
  p_full_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_i == PCT_W'(WIN_LEN)) |-> !en_o);
  p_zero_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_i == '0) |-> en_o);
endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter
  import thr_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int PRIO_W  = 7,
  parameter int PCT_W   = 7,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_cfg_i,
  input  logic [NUM_REQ*PCT_W-1:0]  cpu_pct_cfg_i,
  input  logic [NUM_REQ*2-1:0]      gpu_lvl_cfg_i,
  output logic                      cpu_clk_en_o,
  output logic                      gpu_clk_en_o,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o
);
  localparam int PH_W = $clog2(WIN_LEN);

  logic [PH_W-1:0]  phase_q;
  logic             win_end, win_start;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [PCT_W-1:0] cpu_raw, cpu_sel, gpu_sel;
  logic             win_valid_q;
  logic [IDX_W-1:0] win_idx_q;
  logic [PCT_W-1:0] depth_q [2];
  logic [1:0]       en;

  assign win_end   = phase_q == PH_W'(WIN_LEN - 1);
  assign win_start = phase_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (win_end) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  thr_prio_pick #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .req_i   (req_i),
    .prio_i  (prio_cfg_i),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  assign cpu_raw = cpu_pct_cfg_i[pick_idx*PCT_W +: PCT_W];
  assign cpu_sel = (cpu_raw > PCT_W'(WIN_LEN)) ? PCT_W'(WIN_LEN) : cpu_raw;
  assign gpu_sel = PCT_W'(lvl_to_pct(gpu_lvl_e'(gpu_lvl_cfg_i[pick_idx*2 +: 2])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_q <= 1'b0;
      win_idx_q   <= '0;
      depth_q[0]  <= '0;
      depth_q[1]  <= '0;
    end else if (win_end) begin
      win_valid_q <= pick_found;
      win_idx_q   <= pick_idx;
      depth_q[0]  <= pick_found ? cpu_sel : '0;
      depth_q[1]  <= pick_found ? gpu_sel : '0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_skip
    thr_pulse_skip #(.PCT_W(PCT_W)) u_skip (
      .clk         (clk),
      .rst_n       (rst_n),
      .depth_i     (depth_q[g]),
      .win_start_i (win_start),
      .win_end_i   (win_end),
      .en_o        (en[g])
    );
  end

  assign cpu_clk_en_o = en[0];
  assign gpu_clk_en_o = en[1];
  assign win_valid_o  = win_valid_q;
  assign win_idx_o    = win_idx_q;

  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PH_W'(WIN_LEN));
  p_hold_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(win_idx_q) && $stable(win_valid_q)
                 && $stable(depth_q[0]) && $stable(depth_q[1]));
  p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_q |-> cpu_clk_en_o && gpu_clk_en_o);
  p_winner_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> req_i[pick_idx]);
  p_depth_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q[0] <= PCT_W'(WIN_LEN));
endmodule

// File: tb/throttle_arbiter_test.sv
`timescale 1ns/1ps
module throttle_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [27:0] prio_cfg = {7'd80, 7'd50, 7'd100, 7'd80};
  logic [27:0] cpu_cfg  = {7'd120, 7'd75, 7'd85, 7'd50};
  logic [7:0]  gpu_cfg  = {2'd0, 2'd2, 2'd3, 2'd1};
  logic       cpu_en, gpu_en, wvalid;
  logic [1:0] widx;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  throttle_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_cfg_i(prio_cfg),
    .cpu_pct_cfg_i(cpu_cfg), .gpu_lvl_cfg_i(gpu_cfg),
    .cpu_clk_en_o(cpu_en), .gpu_clk_en_o(gpu_en),
    .win_valid_o(wvalid), .win_idx_o(widx)
  );

  // {req[3:0], valid, idx[1:0], cpu N[6:0], gpu N[6:0]}
  localparam logic [20:0] VEC [9] = '{
    {4'b0000, 1'b0, 2'd0, 7'd0,   7'd0},
    {4'b0001, 1'b1, 2'd0, 7'd50,  7'd50},
    {4'b0011, 1'b1, 2'd1, 7'd85,  7'd85},
    {4'b0100, 1'b1, 2'd2, 7'd75,  7'd75},
    {4'b1001, 1'b1, 2'd0, 7'd50,  7'd50},   // R3 tie 80/80
    {4'b1000, 1'b1, 2'd3, 7'd100, 7'd0},    // R8 clamp 120
    {4'b0110, 1'b1, 2'd1, 7'd85,  7'd85},
    {4'b1100, 1'b1, 2'd3, 7'd100, 7'd0},
    {4'b0000, 1'b0, 2'd0, 7'd0,   7'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_en(input int n, input int p);
    return ((p + 1) * n) / 100 == (p * n) / 100;
  endfunction

  // Called at phase 0; returns at phase 0 of the next window.
  task automatic run_window(input bit ev, input int eidx, input int ncpu,
                            input int ngpu, input int chg_ph, input logic [3:0] chg_req);
    int cpu_cnt = 0, gpu_cnt = 0, spread_bad = 0, hold_bad = 0;
    chk("R2 valid", wvalid, ev);
    if (ev) chk("R2 index", widx, eidx);
    for (int p = 0; p < 100; p++) begin
      if (p == chg_ph) req = chg_req;
      cpu_cnt += cpu_en;
      gpu_cnt += gpu_en;
      if (cpu_en != exp_en(ncpu, p)) spread_bad++;
      if (gpu_en != exp_en(ngpu, p)) spread_bad++;
      if (wvalid != ev || (ev && widx != eidx)) hold_bad++;
      @(negedge clk);
    end
    chk("R5 cpu pulses", cpu_cnt, 100 - ncpu);
    chk("R6 gpu pulses", gpu_cnt, 100 - ngpu);
    chk("R5 spread", spread_bad, 0);
    chk("R4 hold", hold_bad, 0);
    if (!ev) chk("R7 idle", cpu_cnt + gpu_cnt, 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", wvalid, 0);
    chk("R1 reset cpu_en", cpu_en, 1);
    rst_n = 1'b1;
    chk("R1 first cpu_en", cpu_en, 1);
    chk("R1 first gpu_en", gpu_en, 1);
    for (int k = 0; k < 9; k++) begin
      req = VEC[k][20:17];
      if (k == 0) run_window(0, 0, 0, 0, -1, '0);
      else run_window(VEC[k-1][16], int'(VEC[k-1][15:14]), int'(VEC[k-1][13:7]),
                      int'(VEC[k-1][6:0]), -1, '0);
    end
    // R4: change mid-window; only the value at phase 99 counts
    req = 4'b0001;
    run_window(0, 0, 0, 0, 50, 4'b0010);
    req = 4'b0000;
    run_window(1, 1, 85, 85, -1, '0);
    // R4: short request that ends before the sample point is ignored
    req = 4'b0100;
    run_window(0, 0, 0, 0, 60, 4'b0000);
    run_window(0, 0, 0, 0, -1, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule